// File: doc/BRIEF.md
# Load/Store Decode and Byte-Lane Steering

This block sits between the instruction decoder of a 32-bit core and its data bus. Given one memory instruction, the operand register values and the word read back from memory, it works out whether the instruction is a load or a store and how wide the access is. It forms the effective address and sets the byte enables. On a store it moves the register data into the correct byte lanes. On a load it pulls the addressed bytes back out of the returned word and zero-extends them into the destination value. Bits are numbered big-endian throughout: instruction bit 0 is the most significant bit, and memory byte 0 of a word travels on the most significant lane.

Two encodings are handled. The immediate form adds a sign-extended 16-bit immediate to Ra. The register form carries an 11-bit function field that picks one of four behaviours: a plain access at Ra + Rb, a byte-reversed access, a wide access that places Ra and Rb side by side as a 64-bit address, or, on the word store only, an exclusive store. A single reservation bit held in the block gates the exclusive store, and that store always clears the bit. Function-field values outside these four raise an illegal flag and block the request. The whole path is combinational apart from the reservation bit.

Top module: `lsu_steer`

## Requirements
- R1: The opcode is instr_i[31:26], the destination index instr_i[25:21], the function field instr_i[10:0] and the immediate instr_i[15:0]. Opcodes 11_0_s_zz (register form) and 11_1_s_zz (immediate form) with zz not 11 are memory operations: s=1 means store, and zz 00/01/10 means byte/halfword/word, which also appears on size_o. Any other opcode raises none of req_o, illegal_o or wb_en_o.
- R2: An immediate-form access uses address Ra + sign-extended immediate, and the upper 32 bits of addr_o are zero.
- R3: A register-form access with function field 0x000 uses address Ra + Rb, with the upper 32 bits zero.
- R4: Function field 0x080 gives a wide access: addr_o = {Ra, Rb}, and the lane selection uses Rb's low bits.
- R5: A byte store puts rd_i[7:0] on the lane chosen by address bits [1:0]. Lane 0 is wdata_o[31:24] with be_o[3], and lane 3 is wdata_o[7:0] with be_o[0]. Exactly one enable is set.
- R6: A halfword store uses lanes 0-1 (be 1100) when address bit 1 is 0 and lanes 2-3 (be 0011) when it is 1, with rd_i[15:8] on the lower-numbered lane. A word store sets be 1111 and sends rd_i unchanged. Unused lanes carry zero.
- R7: A byte load returns the addressed lane in wb_data_o[7:0] with the upper bits zero. A halfword load returns the two addressed lanes, lower-numbered lane in bits [15:8], with bits [31:16] zero. A word load returns rdata_i.
- R8: Function field 0x200 reverses the byte order within the accessed unit, for stores before placement and for loads after extraction. For a byte access it changes nothing.
- R9: Function field 0x400 on opcode 110110 is an exclusive store. It raises req_o and we_o only while resv_o is 1, and resv_o is 0 in the cycle after it, whether or not it wrote.
- R10: resv_o is 0 after reset. It becomes 1 in the cycle after resv_set_i is high, unless an exclusive store is presented in that same cycle, in which case the clear takes priority.
- R11: A register-form function field other than the four above, or 0x400 on any opcode except 110110, raises illegal_o and keeps req_o and wb_en_o low.
- R12: A legal store raises req_o and we_o. A legal load raises req_o and wb_en_o and reports wb_idx_o = instr_i[25:21]. be_o is all zero whenever req_o is low. Nothing is raised while valid_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| ra_i | input | 32 | Value of register Ra |
| rb_i | input | 32 | Value of register Rb |
| rd_i | input | 32 | Value of register Rd (store source) |
| rdata_i | input | 32 | Read data returned by memory |
| resv_set_i | input | 1 | Sets the reservation bit |
| req_o | output | 1 | Memory request |
| we_o | output | 1 | Request is a write |
| addr_o | output | 64 | Effective address |
| size_o | output | 2 | Access size: 0 byte, 1 half, 2 word |
| be_o | output | 4 | Byte enables, bit 3 = lane 0 |
| wdata_o | output | 32 | Lane-aligned store data |
| illegal_o | output | 1 | Unrecognised function field |
| wb_en_o | output | 1 | Load result valid for writeback |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Zero-extended load result |
| resv_o | output | 1 | Reservation bit |

## Verification
The bench sweeps every lane offset for byte and halfword accesses, in both normal and reversed order. A design that reversed the lane numbering would put a byte at address 0 onto wdata_o[7:0], and one that skipped the reversal would write halfwords backwards; both show up as wrong enables or data. Wide accesses are combined with non-zero low Ra bits, so a design that added the operands or took lane bits from Ra produces a wrong address or lane. The reservation sequences cover an exclusive store with the bit clear, an exclusive store with it set, and a set pulse in the same cycle as an exclusive store, which catches a design that lets the set win or leaves the bit set after a failed attempt. Illegal encodings, including the exclusive code on byte stores and on loads, must stay silent on the bus.

// File: rtl/lsu_steer_pkg.sv
package lsu_steer_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_NONE = 2'd3
   } size_e;

   localparam logic [10:0] FN_PLAIN = 11'h000;
   localparam logic [10:0] FN_SWAP  = 11'h200;
   localparam logic [10:0] FN_WIDE  = 11'h080;
   localparam logic [10:0] FN_EXCL  = 11'h400;

   typedef struct packed {
      logic  mem;
      logic  store;
      logic  imm;
      logic  swap;
      logic  wide;
      logic  excl;
      logic  bad;
      size_e size;
   } dec_t;

endpackage

// File: rtl/lsu_steer_dec.sv
module lsu_steer_dec
   import lsu_steer_pkg::*;
#(
   parameter bit SWAP_EN = 1'b1,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic [5:0]  op_i,
   input  logic [10:0] fn_i,
   output dec_t        dec_o
);

   always_comb begin
      dec_o = '0;
      if (op_i[5:4] == 2'b11 && op_i[1:0] != 2'b11) begin
         dec_o.mem   = 1'b1;
         dec_o.store = op_i[2];
         dec_o.imm   = op_i[3];
         dec_o.size  = size_e'(op_i[1:0]);
         if (!op_i[3]) begin
            case (fn_i)
               FN_PLAIN: dec_o.bad = 1'b0;
               FN_SWAP: begin
                  if (SWAP_EN) dec_o.swap = 1'b1;
                  else         dec_o.bad  = 1'b1;
               end
               FN_WIDE: begin
                  if (WIDE_EN) dec_o.wide = 1'b1;
                  else         dec_o.bad  = 1'b1;
               end
               FN_EXCL: begin
                  if (op_i[2] && op_i[1:0] == 2'b10) dec_o.excl = 1'b1;
                  else                               dec_o.bad  = 1'b1;
               end
               default: dec_o.bad = 1'b1;
            endcase
         end
      end
   end

endmodule

// File: rtl/lsu_steer_agen.sv
module lsu_steer_agen #(
   parameter int DATA_W  = 32,
   parameter bit WIDE_EN = 1'b1,
   parameter int ADDR_W  = 64,
   parameter int LB      = 2
) (
   input  logic [DATA_W-1:0] ra_i,
   input  logic [DATA_W-1:0] rb_i,
   input  logic [15:0]       imm_i,
   input  logic              use_imm_i,
   input  logic              wide_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LB-1:0]     low_o
);

   logic [DATA_W-1:0] offs;
   logic [DATA_W-1:0] sum;

   assign offs = use_imm_i ? {{(DATA_W-16){imm_i[15]}}, imm_i} : rb_i;
   assign sum  = ra_i + offs;

   generate
      if (WIDE_EN) begin : g_wide
         assign addr_o = wide_i ? {ra_i, rb_i} : {{DATA_W{1'b0}}, sum};
         assign low_o  = wide_i ? rb_i[LB-1:0] : sum[LB-1:0];
      end else begin : g_flat
         logic unused_wide;
         assign unused_wide = wide_i;
         assign addr_o      = sum;
         assign low_o       = sum[LB-1:0];
      end
   endgenerate

endmodule

// File: rtl/lsu_steer_lanes.sv
module lsu_steer_lanes
   import lsu_steer_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int NL    = DATA_W / 8,
   localparam int LB    = $clog2(NL)
) (
   input  size_e             size_i,
   input  logic              swap_i,
   input  logic [LB-1:0]     low_i,
   input  logic [DATA_W-1:0] st_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [NL-1:0]     be_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic [DATA_W-1:0] ld_o
);

   logic [LB-1:0] mask;
   logic [LB-1:0] base;

   always_comb begin
      case (size_i)
         SZ_BYTE: mask = '0;
         SZ_HALF: mask = LB'(1);
         default: mask = '1;
      endcase
   end

   assign base = low_i & ~mask;

   // store side: lane gi holds memory byte gi of the word
   generate
      for (genvar gi = 0; gi < NL; gi++) begin : g_lane
         logic [LB-1:0] k;
         logic [LB-1:0] j;
         logic          hit;
         logic [7:0]    lane_w;
         always_comb begin
            hit    = ((LB'(gi) & ~mask) == base);
            k      = LB'(gi) - base;
            j      = swap_i ? k : (mask - k);
            lane_w = hit ? st_i[8*int'(j) +: 8] : 8'h00;
         end
         assign wdata_o[8*(NL-1-gi) +: 8] = lane_w;
         assign be_o[NL-1-gi]             = hit;
      end

      // load side: result byte gj, counted from the LSB
      for (genvar gj = 0; gj < NL; gj++) begin : g_res
         logic [LB-1:0] kk;
         logic [LB-1:0] ln;
         logic          in_unit;
         logic [7:0]    res_b;
         always_comb begin
            in_unit = (LB'(gj) <= mask);
            kk      = swap_i ? LB'(gj) : (mask - LB'(gj));
            ln      = base + kk;
            res_b   = in_unit ? rdata_i[8*(NL-1-int'(ln)) +: 8] : 8'h00;
         end
         assign ld_o[8*gj +: 8] = res_b;
      end
   endgenerate

endmodule

// File: rtl/lsu_steer.sv
module lsu_steer
   import lsu_steer_pkg::*;
#(
   parameter int  DATA_W  = 32,
   parameter bit  SWAP_EN = 1'b1,
   parameter bit  WIDE_EN = 1'b1,
   localparam int NL      = DATA_W / 8,
   localparam int LB      = $clog2(NL),
   localparam int ADDR_W  = WIDE_EN ? 2 * DATA_W : DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [31:0]       instr_i,
   input  logic [DATA_W-1:0] ra_i,
   input  logic [DATA_W-1:0] rb_i,
   input  logic [DATA_W-1:0] rd_i,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic              resv_set_i,
   output logic              req_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [1:0]        size_o,
   output logic [NL-1:0]     be_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              illegal_o,
   output logic              wb_en_o,
   output logic [4:0]        wb_idx_o,
   output logic [DATA_W-1:0] wb_data_o,
   output logic              resv_o
);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("lsu_steer: DATA_W must be 32, the encoding only sizes up to a word");
      end
   endgenerate

   dec_t            dec;
   logic [LB-1:0]   low;
   logic [NL-1:0]   be_raw;
   logic            legal;
   logic            go;
   logic            resv_q;
   logic            unused_ra_idx;

   assign unused_ra_idx = ^instr_i[20:16];

   lsu_steer_dec #(
      .SWAP_EN (SWAP_EN),
      .WIDE_EN (WIDE_EN)
   ) u_dec (
      .op_i  (instr_i[31:26]),
      .fn_i  (instr_i[10:0]),
      .dec_o (dec)
   );

   lsu_steer_agen #(
      .DATA_W  (DATA_W),
      .WIDE_EN (WIDE_EN),
      .ADDR_W  (ADDR_W),
      .LB      (LB)
   ) u_agen (
      .ra_i      (ra_i),
      .rb_i      (rb_i),
      .imm_i     (instr_i[15:0]),
      .use_imm_i (dec.imm),
      .wide_i    (dec.wide),
      .addr_o    (addr_o),
      .low_o     (low)
   );

   lsu_steer_lanes #(
      .DATA_W (DATA_W)
   ) u_lanes (
      .size_i  (dec.size),
      .swap_i  (dec.swap),
      .low_i   (low),
      .st_i    (rd_i),
      .rdata_i (rdata_i),
      .be_o    (be_raw),
      .wdata_o (wdata_o),
      .ld_o    (wb_data_o)
   );

   assign legal     = valid_i & dec.mem & ~dec.bad;
   assign go        = legal & (~dec.excl | resv_q);
   assign req_o     = go;
   assign we_o      = go & dec.store;
   assign be_o      = go ? be_raw : '0;
   assign size_o    = dec.size;
   assign illegal_o = valid_i & dec.mem & dec.bad;
   assign wb_en_o   = legal & ~dec.store;
   assign wb_idx_o  = instr_i[25:21];
   assign resv_o    = resv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 resv_q <= 1'b0;
      else if (legal && dec.excl) resv_q <= 1'b0;
      else if (resv_set_i)        resv_q <= 1'b1;
   end

endmodule

// File: rtl/lsu_steer_chk.sv
module lsu_steer_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 64,
   parameter int NL     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              valid_i,
   input logic [31:0]       instr_i,
   input logic [DATA_W-1:0] ra_i,
   input logic [DATA_W-1:0] rb_i,
   input logic              resv_set_i,
   input logic              req_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic [1:0]        size_o,
   input logic [NL-1:0]     be_o,
   input logic              illegal_o,
   input logic              wb_en_o,
   input logic              resv_o
);

   logic excl_ins;
   logic wide_ins;
   logic imm_ins;

   assign excl_ins = (instr_i[31:26] == 6'b110110) && (instr_i[10:0] == 11'h400);
   assign wide_ins = (instr_i[31:29] == 3'b110) && (instr_i[27:26] != 2'b11)
                     && (instr_i[10:0] == 11'h080);
   assign imm_ins  = (instr_i[31:29] == 3'b111);

   // R9
   excl_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && excl_ins && !resv_o) |-> !req_o);

   // R9
   excl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && excl_ins) |=> !resv_o);

   // R10
   resv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resv_set_i && !(valid_i && excl_ins)) |=> resv_o);

   // R11
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (!req_o && !wb_en_o));

   // R12
   be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_o |-> (be_o == '0));

   // R5
   byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && size_o == 2'd0) |-> ($countones(be_o) == 1));

   // R2
   imm_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && imm_ins) |->
      (addr_o[DATA_W-1:0] == ra_i + {{(DATA_W-16){instr_i[15]}}, instr_i[15:0]}));

   generate
      if (ADDR_W == 2 * DATA_W) begin : g_wide_chk
         // R4
         wide_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o && wide_ins) |-> (addr_o == {ra_i, rb_i}));
      end
   endgenerate

endmodule

bind lsu_steer lsu_steer_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .NL     (NL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .valid_i    (valid_i),
   .instr_i    (instr_i),
   .ra_i       (ra_i),
   .rb_i       (rb_i),
   .resv_set_i (resv_set_i),
   .req_o      (req_o),
   .addr_o     (addr_o),
   .size_o     (size_o),
   .be_o       (be_o),
   .illegal_o  (illegal_o),
   .wb_en_o    (wb_en_o),
   .resv_o     (resv_o)
);

// File: tb/lsu_steer_tb.sv
`timescale 1ns/1ps
module lsu_steer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [31:0] instr_i = '0;
   logic [31:0] ra_i = '0, rb_i = '0, rd_i = '0, rdata_i = '0;
   logic        resv_set_i = 1'b0;
   logic        req_o, we_o, illegal_o, wb_en_o, resv_o;
   logic [63:0] addr_o;
   logic [1:0]  size_o;
   logic [3:0]  be_o;
   logic [31:0] wdata_o, wb_data_o;
   logic [4:0]  wb_idx_o;

   always #4 clk = ~clk;

   lsu_steer u_dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
      .ra_i(ra_i), .rb_i(rb_i), .rd_i(rd_i), .rdata_i(rdata_i),
      .resv_set_i(resv_set_i), .req_o(req_o), .we_o(we_o), .addr_o(addr_o),
      .size_o(size_o), .be_o(be_o), .wdata_o(wdata_o), .illegal_o(illegal_o),
      .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o), .resv_o(resv_o)
   );

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   // reference state and expectations
   bit          m_resv = 1'b0;
   bit          e_req, e_we, e_ill, e_wb, e_st, e_imm;
   int          e_kind, e_n;
   logic [63:0] e_addr;
   logic [3:0]  e_be;
   logic [31:0] e_wd, e_ld;

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rform(input logic [5:0] op, input logic [4:0] rd,
                                         input logic [10:0] fn);
      return {op, rd, 5'd1, 5'd2, fn};
   endfunction

   function automatic logic [31:0] iform(input logic [5:0] op, input logic [4:0] rd,
                                         input logic [15:0] imm);
      return {op, rd, 5'd3, imm};
   endfunction

   // kinds: 0 plain, 1 reversed, 2 wide, 3 exclusive, 4 illegal
   task automatic model();
      logic [5:0]  op;
      logic [10:0] fn;
      bit          is_mem;
      int          off;
      logic [31:0] lo;
      op = instr_i[31:26];
      fn = instr_i[10:0];
      is_mem = (op[5:4] == 2'b11) && (op[1:0] != 2'b11);
      e_req = 0; e_we = 0; e_ill = 0; e_wb = 0;
      e_addr = '0; e_be = '0; e_wd = '0; e_ld = '0;
      e_st = op[2]; e_imm = op[3]; e_n = 1 << op[1:0]; e_kind = 0;
      if (!is_mem) return;
      if (!e_imm) begin
         if (fn == 11'h000)      e_kind = 0;
         else if (fn == 11'h200) e_kind = 1;
         else if (fn == 11'h080) e_kind = 2;
         else if (fn == 11'h400) e_kind = (e_st && op[1:0] == 2'b10) ? 3 : 4;
         else                    e_kind = 4;
      end
      if (e_imm) begin
         lo = ra_i + {{16{instr_i[15]}}, instr_i[15:0]};
         e_addr = {32'h0, lo};
      end else if (e_kind == 2) begin
         e_addr = {ra_i, rb_i};
      end else begin
         lo = ra_i + rb_i;
         e_addr = {32'h0, lo};
      end
      off   = (int'(e_addr[1:0]) / e_n) * e_n;
      e_ill = valid_i && e_kind == 4;
      e_req = valid_i && e_kind != 4 && (e_kind != 3 || m_resv);
      e_we  = e_req && e_st;
      e_wb  = valid_i && e_kind != 4 && !e_st;
      for (int k = 0; k < e_n; k++) begin
         int bsel;
         int lane;
         bsel = (e_kind == 1) ? k : (e_n - 1 - k);
         lane = off + k;
         e_wd[8*(3-lane) +: 8] = rd_i[8*bsel +: 8];
         if (e_req) e_be[3-lane] = 1'b1;
      end
      for (int k = 0; k < e_n; k++) begin
         logic [7:0] mb;
         mb = rdata_i[8*(3-(off+k)) +: 8];
         if (e_kind == 1) e_ld = e_ld | (32'(mb) << (8*k));
         else             e_ld = (e_ld << 8) | 32'(mb);
      end
   endtask

   task automatic step(input bit v, input logic [31:0] ins, input logic [31:0] ra,
                       input logic [31:0] rb, input logic [31:0] rd,
                       input logic [31:0] rdat, input bit set);
      string atag, ltag, rtag;
      @(negedge clk);
      valid_i = v; instr_i = ins; ra_i = ra; rb_i = rb; rd_i = rd;
      rdata_i = rdat; resv_set_i = set;
      #2;
      model();
      atag = e_imm ? "R2" : (e_kind == 2 ? "R4" : "R3");
      ltag = (e_kind == 1) ? "R8" : (e_n == 1 ? "R5" : "R6");
      rtag = (e_kind == 3) ? "R9" : "R12";
      chk("R10", "resv_o", 64'(resv_o), 64'(m_resv));
      chk(rtag, "req_o", 64'(req_o), 64'(e_req));
      chk(rtag, "we_o", 64'(we_o), 64'(e_we));
      chk("R11", "illegal_o", 64'(illegal_o), 64'(e_ill));
      chk("R12", "wb_en_o", 64'(wb_en_o), 64'(e_wb));
      chk(ltag, "be_o", 64'(be_o), 64'(e_be));
      if (e_req) begin
         chk(atag, "addr_o", addr_o, e_addr);
         chk("R1", "size_o", 64'(size_o), 64'(instr_i[27:26]));
      end
      if (e_we) chk(ltag, "wdata_o", 64'(wdata_o), 64'(e_wd));
      if (e_wb) begin
         chk((e_kind == 1) ? "R8" : "R7", "wb_data_o", 64'(wb_data_o), 64'(e_ld));
         chk("R12", "wb_idx_o", 64'(wb_idx_o), 64'(instr_i[25:21]));
      end
      @(posedge clk);
      if (valid_i && e_kind == 3) m_resv = 1'b0;
      else if (set)               m_resv = 1'b1;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   localparam logic [31:0] RD = 32'hA1B2C3D4;
   localparam logic [31:0] MEM = 32'h11223344;

   initial begin
      repeat (3) @(negedge clk);
      chk("R10", "resv_o in reset", 64'(resv_o), 64'd0);
      rst_n = 1'b1;

      // R1 non-memory opcode and idle input
      step(1, rform(6'b000000, 5'd4, 11'h000), 32'h10, 32'h4, RD, MEM, 0);
      step(0, rform(6'b110110, 5'd4, 11'h000), 32'h10, 32'h4, RD, MEM, 0);
      // R2 immediate stores, negative and positive offsets
      step(1, iform(6'b111100, 5'd5, 16'hFFFC), 32'h1003, 0, RD, MEM, 0);
      step(1, iform(6'b111101, 5'd5, 16'h0002), 32'h1000, 0, RD, MEM, 0);
      step(1, iform(6'b111110, 5'd5, 16'h8000), 32'h10000, 0, RD, MEM, 0);
      // R5 byte stores at every lane
      for (int a = 0; a < 4; a++)
         step(1, rform(6'b110100, 5'd6, 11'h000), 32'h200, 32'(a), RD, MEM, 0);
      // R6 halfword and word stores
      for (int a = 0; a < 4; a++)
         step(1, rform(6'b110101, 5'd6, 11'h000), 32'h200, 32'(a), RD, MEM, 0);
      step(1, rform(6'b110110, 5'd6, 11'h000), 32'h200, 32'h0, RD, MEM, 0);
      // R7 loads, immediate and register form
      for (int a = 0; a < 4; a++) begin
         step(1, iform(6'b111000, 5'd7, 16'(a)), 32'h300, 0, RD, MEM, 0);
         step(1, iform(6'b111001, 5'd7, 16'(a)), 32'h300, 0, RD, MEM, 0);
      end
      step(1, iform(6'b111010, 5'd8, 16'h0004), 32'h300, 0, RD, MEM, 0);
      step(1, rform(6'b110010, 5'd9, 11'h000), 32'h300, 32'h8, RD, MEM, 0);
      // R8 reversed order
      step(1, rform(6'b110101, 5'd6, 11'h200), 32'h200, 32'h2, RD, MEM, 0);
      step(1, rform(6'b110110, 5'd6, 11'h200), 32'h200, 32'h0, RD, MEM, 0);
      step(1, rform(6'b110001, 5'd6, 11'h200), 32'h200, 32'h0, RD, MEM, 0);
      step(1, rform(6'b110010, 5'd6, 11'h200), 32'h200, 32'h0, RD, MEM, 0);
      step(1, rform(6'b110100, 5'd6, 11'h200), 32'h200, 32'h1, RD, MEM, 0);
      // R4 wide address, lane from Rb
      step(1, rform(6'b110100, 5'd6, 11'h080), 32'hDEAD0003, 32'h00000001, RD, MEM, 0);
      step(1, rform(6'b110000, 5'd6, 11'h080), 32'h00000001, 32'hFFFFFFFE, RD, MEM, 0);
      step(1, rform(6'b110110, 5'd6, 11'h080), 32'hFFFFFFFF, 32'h00000010, RD, MEM, 0);
      // R11 illegal function fields
      step(1, rform(6'b110110, 5'd6, 11'h001), 32'h200, 32'h0, RD, MEM, 0);
      step(1, rform(6'b110100, 5'd6, 11'h400), 32'h200, 32'h0, RD, MEM, 0);
      step(1, rform(6'b110010, 5'd6, 11'h400), 32'h200, 32'h0, RD, MEM, 0);
      // R9 R10 reservation sequences
      step(1, rform(6'b110110, 5'd6, 11'h400), 32'h400, 32'h0, RD, MEM, 0);
      step(0, 32'h0, 0, 0, RD, MEM, 1);
      step(0, 32'h0, 0, 0, RD, MEM, 0);
      step(1, rform(6'b110110, 5'd6, 11'h400), 32'h400, 32'h0, RD, MEM, 0);
      step(1, rform(6'b110110, 5'd6, 11'h400), 32'h400, 32'h0, RD, MEM, 0);
      step(0, 32'h0, 0, 0, RD, MEM, 1);
      step(1, rform(6'b110110, 5'd6, 11'h400), 32'h400, 32'h0, RD, MEM, 1);
      step(0, 32'h0, 0, 0, RD, MEM, 0);

      // mixed traffic
      for (int t = 0; t < 600; t++) begin
         logic [5:0]  op;
         logic [10:0] fn;
         logic [31:0] ins;
         case ($urandom_range(0, 13))
            0: op = 6'b110000;  1: op = 6'b110001;  2: op = 6'b110010;
            3: op = 6'b110100;  4: op = 6'b110101;  5: op = 6'b110110;
            6: op = 6'b111000;  7: op = 6'b111001;  8: op = 6'b111010;
            9: op = 6'b111100; 10: op = 6'b111101; 11: op = 6'b111110;
            12: op = 6'b110011; default: op = 6'b000101;
         endcase
         case ($urandom_range(0, 5))
            0, 1: fn = 11'h000;
            2: fn = 11'h200;
            3: fn = 11'h080;
            4: fn = 11'h400;
            default: fn = 11'($urandom);
         endcase
         ins = {op, 5'($urandom), 10'($urandom), fn};
         step($urandom_range(0, 7) != 0, ins, $urandom, $urandom, $urandom,
              $urandom, $urandom_range(0, 3) == 0);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule